// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block is the switching core of a time-division-multiplexed exchange. One channel slot passes per clock cycle. Its byte is written into a data store that holds two banks. While one frame is being written into one bank, output slots read the other bank, which holds the frame before. Each output slot has a connection entry. The entry selects one of three outcomes for the slot:
- forward the byte that a chosen input channel carried one frame earlier;
- send a fixed message byte;
- keep the slot silent.

The entry also carries a per-slot output-enable and a stream direction flag.

A control port writes connection entries into a shadow store. The whole shadow store becomes the live map at the next frame boundary, so a frame never sees a half-updated map. A frame boundary is a frame pulse, or the automatic wrap after the last slot. A small synchroniser state machine gates the datapath. Its states are:
- `ST_WAIT`: after reset, waiting for the first frame pulse.
- `ST_FIRST`: the first frame. The read bank holds no data yet.
- `ST_RUN`: steady switching.

Its transitions are:
- `ST_WAIT`→`ST_FIRST` on a frame pulse.
- `ST_FIRST`→`ST_RUN` on the next frame boundary.
- `ST_RUN` holds until reset.

Top module: `tsi_switch`

## Requirements
- R1: While reset is asserted and right after it, `out_valid_o` and `out_oe_o` are 0 and `out_byte_o` is the idle byte 0xFF. All connection entries reset to zero, meaning output disabled and no message mode.
- R2: Before the first frame pulse, input bytes are ignored and no output slot is produced. Whenever `out_valid_o` is 0, `out_oe_o` is 0 and `out_byte_o` is 0xFF.
- R3: The result for the slot presented in clock cycle t appears in cycle t+1, with `out_valid_o`=1 and `out_slot_o` equal to that slot number. A cycle with `frame_pulse_i` high is slot 0.
- R4: Connection data bits are {dir[11], msg[10], oe[9], src8[8], low[7:0]}. With oe=1 and msg=1, the output byte is `low`.
- R5: With oe=1, msg=0 and source {src8,low} below NUM_CH, the output byte is the byte that source channel carried in the previous frame.
- R6: With oe=1, msg=0 and source {src8,low} of NUM_CH or more, the output byte is 0xFF.
- R7: With oe=0, `out_oe_o` is 0 and `out_byte_o` is 0xFF, whatever msg and source say.
- R8: `out_dir_o` carries the dir bit of the slot's live entry. A value of 1 means the first line of the pair is the input.
- R9: A control write lands in the shadow store. It governs output only from the first frame boundary strictly after the write cycle. A write to the entry of the slot in progress leaves that slot's output unchanged. Writes with address NUM_CH or more are dropped.
- R10: In the first frame after synchronisation, switched slots (oe=1, msg=0) output 0xFF. Message slots already work in that frame.
- R11: After slot NUM_CH-1 the slot count wraps to 0, and that wrap is a frame boundary. A frame pulse in mid-frame restarts at slot 0 as a boundary. Bank entries not rewritten in a short frame keep their older contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one channel per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_pulse_i | input | 1 | Marks the current cycle as slot 0 of a new frame |
| in_byte_i | input | 8 | Input channel byte for the current slot |
| cfg_we_i | input | 1 | Connection entry write strobe |
| cfg_addr_i | input | AW | Output slot whose entry is written |
| cfg_data_i | input | 12 | Entry value {dir, msg, oe, src8, low[7:0]} |
| out_valid_o | output | 1 | An output slot result is present |
| out_slot_o | output | AW | Slot number of the present result |
| out_byte_o | output | 8 | Output byte for that slot |
| out_oe_o | output | 1 | Driver enable for that slot |
| out_dir_o | output | 1 | Stream direction flag for that slot |

## Verification
The control port can rewrite an entry while the datapath is reading a live entry in the same cycle. This includes the entry of the very slot being switched, and a write landing on the frame-boundary cycle itself. The bench provokes both. In one frame it writes the entry of slot 50 during slot 50 and a far-ahead entry during slot 10, and it writes entry 0 during a frame-pulse cycle. A scoreboard model applies each write only to its shadow map and copies that map at boundaries. It then judges that the slot in progress keeps its old result, and that the new value shows exactly from the following frame.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    localparam int BYTE_W  = 8;
    localparam int SRC_W   = 9;
    localparam int ENTRY_W = 12;
    localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;

    // One connection entry: direction, message mode, driver enable, source
    typedef struct packed {
        logic              dir;
        logic              msg;
        logic              oe;
        logic              src8;
        logic [BYTE_W-1:0] low;
    } conn_entry_t;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_FIRST = 2'd1,
        ST_RUN   = 2'd2
    } sync_state_e;

endpackage

// File: rtl/tsi_frame_ctl.sv
module tsi_frame_ctl
    import tsi_pkg::*;
#(
    parameter int NUM_CH = 384,
    localparam int AW = $clog2(NUM_CH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_pulse_i,
    output logic          slot_valid_o,
    output logic [AW-1:0] slot_o,
    output logic          boundary_o,
    output logic          wr_bank_o,
    output logic          prev_ok_o
);

    localparam logic [AW-1:0] LAST_SLOT = AW'(NUM_CH - 1);

    sync_state_e   state_q, state_d;
    logic [AW-1:0] next_q, next_d;
    logic          bank_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            next_q  <= '0;
            bank_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            next_q  <= next_d;
            bank_q  <= wr_bank_o;
        end
    end

    // Next state and per-cycle slot outputs
    always_comb begin
        state_d      = state_q;
        slot_valid_o = frame_pulse_i || (state_q != ST_WAIT);
        slot_o       = frame_pulse_i ? '0 : next_q;
        boundary_o   = frame_pulse_i || ((state_q != ST_WAIT) && (next_q == '0));
        wr_bank_o    = boundary_o ? ~bank_q : bank_q;
        prev_ok_o    = 1'b0;
        unique case (state_q)
            ST_WAIT: begin
                if (frame_pulse_i) state_d = ST_FIRST;
            end
            ST_FIRST: begin
                if (boundary_o) begin
                    state_d   = ST_RUN;
                    prev_ok_o = 1'b1;
                end
            end
            ST_RUN: begin
                prev_ok_o = 1'b1;
            end
            default: begin
                state_d = ST_WAIT;
            end
        endcase
        if (!slot_valid_o)           next_d = '0;
        else if (slot_o == LAST_SLOT) next_d = '0;
        else                          next_d = slot_o + AW'(1);
    end

endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
    import tsi_pkg::*;
#(
    parameter int NUM_CH = 384,
    localparam int AW = $clog2(NUM_CH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  conn_entry_t   wr_data_i,
    input  logic          boundary_i,
    input  logic [AW-1:0] rd_addr_i,
    output conn_entry_t   rd_entry_o
);

    conn_entry_t shadow_q [NUM_CH];
    conn_entry_t live_q   [NUM_CH];

    logic          wr_ok;
    logic [AW-1:0] rd_idx;

    assign wr_ok  = wr_en_i && (int'(wr_addr_i) < NUM_CH);
    assign rd_idx = (int'(rd_addr_i) < NUM_CH) ? rd_addr_i : '0;

    // Shadow takes control writes; live copies the shadow at each boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                shadow_q[i] <= '0;
                live_q[i]   <= '0;
            end
        end else begin
            if (wr_ok) shadow_q[wr_addr_i] <= wr_data_i;
            if (boundary_i) begin
                for (int i = 0; i < NUM_CH; i++) live_q[i] <= shadow_q[i];
            end
        end
    end

    // On a boundary cycle the live copy is not loaded yet: read the shadow
    assign rd_entry_o = boundary_i ? shadow_q[rd_idx] : live_q[rd_idx];

endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
    import tsi_pkg::*;
#(
    parameter int NUM_CH = 384,
    parameter int NUM_BANKS = 2,
    localparam int AW = $clog2(NUM_CH + 1),
    localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [BW-1:0]     wr_bank_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [BYTE_W-1:0] wr_byte_i,
    input  logic [BW-1:0]     rd_bank_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic [BYTE_W-1:0] rd_byte_o
);

    logic [BYTE_W-1:0] bank_rd [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [BYTE_W-1:0] store_q [NUM_CH];
        logic              hit;

        assign hit = wr_en_i && (wr_bank_i == BW'(b)) && (int'(wr_addr_i) < NUM_CH);

        always_ff @(posedge clk) begin
            if (hit) store_q[wr_addr_i] <= wr_byte_i;
        end

        assign bank_rd[b] = (int'(rd_addr_i) < NUM_CH) ? store_q[rd_addr_i] : IDLE_BYTE;
    end

    always_comb begin
        rd_byte_o = IDLE_BYTE;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (rd_bank_i == BW'(b)) rd_byte_o = bank_rd[b];
        end
    end

endmodule

// File: rtl/tsi_out_stage.sv
module tsi_out_stage
    import tsi_pkg::*;
#(
    parameter int NUM_CH = 384,
    localparam int AW = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_valid_i,
    input  logic [AW-1:0]     slot_i,
    input  conn_entry_t       entry_i,
    input  logic              src_ok_i,
    input  logic              prev_ok_i,
    input  logic [BYTE_W-1:0] rd_byte_i,
    output logic              out_valid_o,
    output logic [AW-1:0]     out_slot_o,
    output logic [BYTE_W-1:0] out_byte_o,
    output logic              out_oe_o,
    output logic              out_dir_o
);

    logic [BYTE_W-1:0] byte_d;

    always_comb begin
        if (!slot_valid_i || !entry_i.oe)   byte_d = IDLE_BYTE;
        else if (entry_i.msg)               byte_d = entry_i.low;
        else if (!prev_ok_i || !src_ok_i)   byte_d = IDLE_BYTE;
        else                                byte_d = rd_byte_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            out_slot_o  <= '0;
            out_byte_o  <= IDLE_BYTE;
            out_oe_o    <= 1'b0;
            out_dir_o   <= 1'b0;
        end else begin
            out_valid_o <= slot_valid_i;
            out_slot_o  <= slot_valid_i ? slot_i : '0;
            out_byte_o  <= byte_d;
            out_oe_o    <= slot_valid_i && entry_i.oe;
            out_dir_o   <= slot_valid_i && entry_i.dir;
        end
    end

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int NUM_CH = 384,
    localparam int AW = $clog2(NUM_CH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_pulse_i,
    input  logic [BYTE_W-1:0]  in_byte_i,
    input  logic               cfg_we_i,
    input  logic [AW-1:0]      cfg_addr_i,
    input  logic [ENTRY_W-1:0] cfg_data_i,
    output logic               out_valid_o,
    output logic [AW-1:0]      out_slot_o,
    output logic [BYTE_W-1:0]  out_byte_o,
    output logic               out_oe_o,
    output logic               out_dir_o
);

    logic              slot_valid;
    logic [AW-1:0]     slot;
    logic              boundary;
    logic              wr_bank;
    logic              prev_ok;
    conn_entry_t       lookup_entry;
    logic [SRC_W-1:0]  src_addr;
    logic              src_ok;
    logic [AW-1:0]     rd_idx;
    logic [BYTE_W-1:0] rd_byte;

    tsi_frame_ctl #(.NUM_CH(NUM_CH)) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_pulse_i(frame_pulse_i),
        .slot_valid_o (slot_valid),
        .slot_o       (slot),
        .boundary_o   (boundary),
        .wr_bank_o    (wr_bank),
        .prev_ok_o    (prev_ok)
    );

    tsi_conn_mem #(.NUM_CH(NUM_CH)) u_conn (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (cfg_we_i),
        .wr_addr_i (cfg_addr_i),
        .wr_data_i (conn_entry_t'(cfg_data_i)),
        .boundary_i(boundary),
        .rd_addr_i (slot),
        .rd_entry_o(lookup_entry)
    );

    assign src_addr = {lookup_entry.src8, lookup_entry.low};
    assign src_ok   = int'(src_addr) < NUM_CH;
    assign rd_idx   = src_ok ? AW'(src_addr) : '0;

    tsi_data_mem #(.NUM_CH(NUM_CH), .NUM_BANKS(2)) u_data (
        .clk      (clk),
        .wr_en_i  (slot_valid),
        .wr_bank_i(wr_bank),
        .wr_addr_i(slot),
        .wr_byte_i(in_byte_i),
        .rd_bank_i(~wr_bank),
        .rd_addr_i(rd_idx),
        .rd_byte_o(rd_byte)
    );

    tsi_out_stage #(.NUM_CH(NUM_CH)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_valid_i(slot_valid),
        .slot_i      (slot),
        .entry_i     (lookup_entry),
        .src_ok_i    (src_ok),
        .prev_ok_i   (prev_ok),
        .rd_byte_i   (rd_byte),
        .out_valid_o (out_valid_o),
        .out_slot_o  (out_slot_o),
        .out_byte_o  (out_byte_o),
        .out_oe_o    (out_oe_o),
        .out_dir_o   (out_dir_o)
    );

endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk
    import tsi_pkg::*;
#(
    parameter int NUM_CH = 384,
    localparam int AW = $clog2(NUM_CH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_pulse_i,
    input logic              slot_valid,
    input conn_entry_t       lookup_entry,
    input logic              out_valid_o,
    input logic [AW-1:0]     out_slot_o,
    input logic [BYTE_W-1:0] out_byte_o,
    input logic              out_oe_o,
    input logic              out_dir_o
);

    // R2
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> (!out_oe_o && out_byte_o == IDLE_BYTE));

    // R7
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_oe_o) |-> out_byte_o == IDLE_BYTE);

    // R3
    pulse_slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse_i |=> (out_valid_o && out_slot_o == '0));

    // R11
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !frame_pulse_i) |=>
            (out_valid_o && out_slot_o == (($past(out_slot_o) == AW'(NUM_CH - 1)) ?
                                           '0 : $past(out_slot_o) + AW'(1))));

    // R4
    msg_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && lookup_entry.oe && lookup_entry.msg) |=>
            out_byte_o == $past(lookup_entry.low));

    // R8
    dir_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid |=> out_dir_o == $past(lookup_entry.dir));

endmodule

bind tsi_switch tsi_switch_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_pulse_i(frame_pulse_i),
    .slot_valid   (slot_valid),
    .lookup_entry (lookup_entry),
    .out_valid_o  (out_valid_o),
    .out_slot_o   (out_slot_o),
    .out_byte_o   (out_byte_o),
    .out_oe_o     (out_oe_o),
    .out_dir_o    (out_dir_o)
);

// File: tb/tsi_switch_tb.sv
module tsi_switch_tb;

    localparam int NUM_CH = 384;
    localparam int AW = $clog2(NUM_CH + 1);

    typedef struct {
        int         slot;
        logic [7:0] b;
        bit         oe;
        bit         dir;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_pulse_i = 1'b0;
    logic [7:0]  in_byte_i = '0;
    logic        cfg_we_i = 1'b0;
    logic [AW-1:0] cfg_addr_i = '0;
    logic [11:0] cfg_data_i = '0;
    logic        out_valid_o;
    logic [AW-1:0] out_slot_o;
    logic [7:0]  out_byte_o;
    logic        out_oe_o;
    logic        out_dir_o;

    always #5 clk = ~clk;

    tsi_switch #(.NUM_CH(NUM_CH)) u_dut (.*);

    int n_checks = 0;
    int n_fails  = 0;
    bit mon_on   = 1'b1;
    bit finished = 1'b0;
    exp_t q[$];

    // Reference model state
    logic [11:0] m_shadow [NUM_CH];
    logic [11:0] m_live   [NUM_CH];
    logic [7:0]  m_dm     [2][NUM_CH];
    logic [11:0] map      [NUM_CH];
    int m_state = 0;
    int m_next  = 0;
    int m_bank  = 0;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] pat(input int k, input int s);
        return 8'((k * 53 + s * 7 + 11) ^ (s >> 3));
    endfunction

    task automatic drive_cycle(input bit fp, input logic [7:0] din,
                               input bit we, input int wa, input logic [11:0] wd);
        bit active, boundary, prev_ok;
        int slot;
        exp_t e;
        logic [11:0] ent;
        int src;
        active   = fp || (m_state != 0);
        slot     = fp ? 0 : m_next;
        boundary = fp || (m_state != 0 && m_next == 0);
        prev_ok  = (m_state == 2) || (m_state == 1 && boundary);
        if (boundary) begin
            for (int i = 0; i < NUM_CH; i++) m_live[i] = m_shadow[i];
            m_bank ^= 1;
        end
        if (active) begin
            ent   = m_live[slot];
            src   = int'(ent[8:0]);
            e.slot = slot;
            e.oe  = ent[9];
            e.dir = ent[11];
            if (!ent[9])                    e.b = 8'hFF;
            else if (ent[10])               e.b = ent[7:0];
            else if (!prev_ok || src >= NUM_CH) e.b = 8'hFF;
            else                            e.b = m_dm[m_bank ^ 1][src];
            if (slot == 0 && (!fp || m_next != 0) && m_state != 0) e.tag = "R11";
            else if ((we && wa == slot) || m_shadow[slot] != m_live[slot]) e.tag = "R9";
            else if (!ent[9])               e.tag = "R7";
            else if (ent[10])               e.tag = "R4";
            else if (!prev_ok)              e.tag = "R10";
            else if (src >= NUM_CH)         e.tag = "R6";
            else                            e.tag = "R5";
            q.push_back(e);
            m_dm[m_bank][slot] = din;
        end
        if (we && wa < NUM_CH) m_shadow[wa] = wd;
        if (m_state == 0 && fp) m_state = 1;
        else if (m_state == 1 && boundary) m_state = 2;
        m_next = !active ? 0 : (slot == NUM_CH - 1) ? 0 : slot + 1;

        frame_pulse_i = fp;
        in_byte_i     = din;
        cfg_we_i      = we;
        cfg_addr_i    = AW'(wa);
        cfg_data_i    = wd;
        @(posedge clk);
        #1;
    endtask

    // One frame of slots, with scripted control writes that collide with the datapath
    task automatic run_frame(input int k, input int len, input bit pulse);
        for (int s = 0; s < len; s++) begin
            bit we = 1'b0;
            int wa = 0;
            logic [11:0] wd = '0;
            if (k == 2 && s == 0)  begin we = 1; wa = 0;   wd = 12'b1_1_1_0_1100_0011; end // R9 boundary-cycle write
            if (k == 2 && s == 10) begin we = 1; wa = 300; wd = 12'b0_1_1_0_1010_0101; end // R9 ahead write
            if (k == 2 && s == 50) begin we = 1; wa = 50;  wd = 12'b1_1_1_0_0101_1010; end // R9 same-slot write
            if (k == 4 && s == 7)  begin we = 1; wa = 450; wd = 12'hFFF; end               // R9 dropped address
            drive_cycle(pulse && s == 0, pat(k, s), we, wa, wd);
        end
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mon_on && out_valid_o) begin
                if (q.size() == 0) begin
                    check("R3", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check("R3", int'(out_slot_o), e.slot);
                    check(e.tag, int'(out_byte_o), int'(e.b));
                    check(e.tag, int'(out_oe_o), int'(e.oe));
                    check("R8", int'(out_dir_o), int'(e.dir));
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NUM_CH; i++) begin
            m_shadow[i] = '0;
            m_live[i]   = '0;
            m_dm[0][i]  = '0;
            m_dm[1][i]  = '0;
        end
        for (int i = 0; i < NUM_CH; i++) begin
            int kind = int'($urandom % 8);
            logic dir = 1'($urandom % 2);
            case (kind)
                0, 1: map[i] = {dir, 1'b1, 1'b1, 1'b0, 8'($urandom)};
                2:    map[i] = {dir, 1'($urandom), 1'b0, 9'($urandom)};
                3:    map[i] = {dir, 1'b0, 1'b1, 9'(NUM_CH + int'($urandom % (512 - NUM_CH)))};
                default: map[i] = {dir, 1'b0, 1'b1, 9'($urandom % NUM_CH)};
            endcase
        end

        // R1: outputs during reset
        repeat (3) @(posedge clk);
        #1;
        check("R1", int'(out_valid_o), 0);
        check("R1", int'(out_oe_o), 0);
        check("R1", int'(out_byte_o), 8'hFF);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", int'(out_valid_o), 0);
        check("R1", int'(out_byte_o), 8'hFF);

        // R2: load the map before any frame pulse; inputs must be ignored
        for (int i = 0; i < NUM_CH; i++) begin
            drive_cycle(1'b0, 8'($urandom), 1'b1, i, map[i]);
            if (i % 48 == 0) begin
                check("R2", int'(out_valid_o), 0);
                check("R2", int'(out_oe_o), 0);
            end
        end

        run_frame(0, NUM_CH, 1'b1);   // R10 first frame
        run_frame(1, NUM_CH, 1'b1);   // R5 R6 R7 R4
        run_frame(2, NUM_CH, 1'b1);   // R9 collisions
        run_frame(3, 200, 1'b1);      // R11 short frame
        run_frame(4, NUM_CH, 1'b1);
        run_frame(5, NUM_CH, 1'b0);   // R11 wrap without pulse
        run_frame(6, NUM_CH, 1'b1);

        @(negedge clk);
        #1;
        mon_on = 1'b0;
        check("R3", q.size(), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule